// File: doc/BRIEF.md
# Page-Mode Burst Read Engine

This block sits on the host side of an asynchronous pseudo-static memory and fetches a short run of 16-bit words with page-mode reads. The host gives a start address and a page-length code for 4, 8 or 16 words. The engine then pulls chip select and output enable low, keeps the upper address bits steady, and waits one full random-access time before it captures the first word. After that it steps only the low page-index bits, and each later word is captured after the shorter page-access time. The index advances modulo the page length from the start word, so a start word that is not aligned wraps around inside the same page.

Captured words leave the engine as a valid/data stream, and the final word carries a last marker. After the final word the memory is deselected and held deselected for the minimum deselect time. The engine then gives a one-cycle done pulse and is ready for a new command. Write enable stays inactive and both byte lanes stay enabled for the whole operation. Every delay is derived from a clock-period parameter by rounding the nanosecond figure up to whole cycles.

Top module: `psram_page_reader`

## Requirements
- R1: During reset and right after it, chip select and output enable are high (inactive), and word_valid, busy and done are all low.
- R2: The length code selects the page size: 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words. The engine delivers exactly that many words, and word_last is high on the final word only.
- R3: While chip select stays low, only the low page-index bits of the address change: bits 1:0 for 4 words, 2:0 for 8 words, 3:0 for 16 words. All higher bits equal those of the start address.
- R4: Word k of a burst (k from 0) comes from the start address with its page-index bits replaced by (start index + k) modulo the page length.
- R5: The first word is captured after RAND_CYC = ceil(70 ns / clock period) clock edges of chip select low. With the default 5 ns clock, word_valid appears 14 cycles after the accept edge.
- R6: Each later word is captured PAGE_CYC = ceil(35 ns / period) cycles after the previous one (7 cycles by default).
- R7: Write enable is held high and both byte enables are held low at all times. Chip select and output enable are low throughout a burst.
- R8: Chip select goes high at the edge that captures the final word and stays high for DESEL_CYC = ceil(15 ns / period) cycles. Done then pulses for one cycle, and busy falls at that same edge.
- R9: A start request made while busy is high has no effect: the running burst continues unchanged and no second burst follows it.
- R10: Chip select never stays low for 40 µs (8000 cycles by default) or longer.
- R11: A start request sampled while idle is accepted at that edge, and chip select falls right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a burst (taken only while idle) |
| start_addr_i | input | ADDR_W | Word address of the first word |
| len_sel_i | input | 2 | Page length code (0:4, 1:8, 2/3:16) |
| busy_o | output | 1 | A burst or the deselect gap is in progress |
| done_o | output | 1 | One-cycle pulse when the engine is ready again |
| word_valid_o | output | 1 | Captured word present |
| word_data_o | output | DATA_W | Captured word |
| word_last_o | output | 1 | Captured word is the final one of the burst |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low (held high) |
| mem_bhe_n_o | output | 1 | Upper byte enable, active low |
| mem_ble_n_o | output | 1 | Lower byte enable, active low |
| mem_dq_i | input | DATA_W | Read data from the memory |

## Verification
A timer limit that is wrong, or a state that leaves too early, captures a word before the memory model has settled. The model returns a marker pattern instead of the stored word, so the data check fails on that word, and the cycle-position check flags the same word. A wrong page index or a lost wrap shows up as a data mismatch within at most one page cycle. A counter that keeps its old value from an earlier burst shifts the word order or the last marker in the very next burst. A state machine that takes a start while busy lowers chip select again during the quiet window after done.

// File: rtl/psram_pr_pkg.sv
`timescale 1ns/1ps
package psram_pr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PAGE  = 2'd2,
    ST_GAP   = 2'd3
  } pr_state_t;

  // round a nanosecond figure up to whole clock cycles, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  // words in a page for a length code
  function automatic logic [4:0] page_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // mask of the address bits that move inside a page
  function automatic logic [3:0] index_mask(input logic [1:0] sel);
    return 4'(page_words(sel) - 5'd1);
  endfunction

endpackage

// File: rtl/psram_pr_timer.sv
`timescale 1ns/1ps
module psram_pr_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/psram_pr_addr_gen.sv
`timescale 1ns/1ps
module psram_pr_addr_gen
  import psram_pr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        mask_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        sel_q;
  logic [3:0]        idx_q;
  logic [3:0]        lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      sel_q  <= sel_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q  <= idx_q + 4'd1;
    end
  end

  assign mask_o = index_mask(sel_q);
  assign lo     = (base_q[3:0] + idx_q) & mask_o;
  assign addr_o = {base_q[ADDR_W-1:4], (base_q[3:0] & ~mask_o) | lo};
  assign last_o = (idx_q == mask_o);
endmodule

// File: rtl/psram_pr_capture.sv
`timescale 1ns/1ps
module psram_pr_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              last_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= take_i;
      last_o  <= take_i & last_i;
      if (take_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/psram_page_reader.sv
`timescale 1ns/1ps
module psram_page_reader
  import psram_pr_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RAND_NS     = 70,
  parameter int T_PAGE_NS     = 35,
  parameter int T_DESEL_NS    = 15,
  parameter int T_CE_MAX_NS   = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        len_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_data_o,
  output logic              word_last_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_bhe_n_o,
  output logic              mem_ble_n_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RAND_CYC   = int'(ns_to_cycles(T_RAND_NS, CLK_PERIOD_NS));
  localparam int PAGE_CYC   = int'(ns_to_cycles(T_PAGE_NS, CLK_PERIOD_NS));
  localparam int DESEL_CYC  = int'(ns_to_cycles(T_DESEL_NS, CLK_PERIOD_NS));
  localparam int CE_MAX_CYC = int'(ns_to_cycles(T_CE_MAX_NS, CLK_PERIOD_NS));
  localparam int TMR_W      = $clog2(RAND_CYC + PAGE_CYC + DESEL_CYC + 1);
  localparam int CEW        = $clog2(CE_MAX_CYC + 1);

  pr_state_t         st_q, st_d;
  logic              tmr_hit, tmr_restart;
  logic [TMR_W-1:0]  tmr_limit;
  logic              start_take, capture_evt, burst_end, word_last;
  logic              selected;
  logic [3:0]        addr_mask;
  logic              done_q;

  // named events used by the control and by the checks below
  assign selected    = (st_q == ST_FIRST) || (st_q == ST_PAGE);
  assign start_take  = (st_q == ST_IDLE) && start_i;
  assign capture_evt = selected && tmr_hit;
  assign burst_end   = (st_q == ST_GAP) && tmr_hit;
  assign tmr_restart = (st_q == ST_IDLE) || tmr_hit;

  always_comb begin
    case (st_q)
      ST_FIRST: tmr_limit = TMR_W'(RAND_CYC - 1);
      ST_PAGE:  tmr_limit = TMR_W'(PAGE_CYC - 1);
      ST_GAP:   tmr_limit = TMR_W'(DESEL_CYC - 1);
      default:  tmr_limit = '0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_take)  st_d = ST_FIRST;
      ST_FIRST,
      ST_PAGE:  if (capture_evt) st_d = word_last ? ST_GAP : ST_PAGE;
      ST_GAP:   if (burst_end)   st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= burst_end;
    end
  end

  psram_pr_timer #(.W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .limit_i   (tmr_limit),
    .hit_o     (tmr_hit)
  );

  psram_pr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_take),
    .step_i (capture_evt),
    .base_i (start_addr_i),
    .sel_i  (len_sel_i),
    .addr_o (mem_addr_o),
    .mask_o (addr_mask),
    .last_o (word_last)
  );

  psram_pr_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (capture_evt),
    .last_i  (word_last),
    .data_i  (mem_dq_i),
    .valid_o (word_valid_o),
    .last_o  (word_last_o),
    .data_o  (word_data_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_ce_n_o  = !selected;
  assign mem_oe_n_o  = !selected;
  assign mem_we_n_o  = 1'b1;
  assign mem_bhe_n_o = 1'b0;
  assign mem_ble_n_o = 1'b0;

  // independent count of consecutive selected cycles, for the checks
  logic [CEW-1:0] ce_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ce_low_cnt <= '0;
    else if (mem_ce_n_o)                  ce_low_cnt <= '0;
    else if (ce_low_cnt != {CEW{1'b1}})   ce_low_cnt <= ce_low_cnt + 1'b1;
  end

  a_r5_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && st_q == ST_FIRST) |-> (int'(ce_low_cnt) >= RAND_CYC - 1));

  a_r10_ce_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ce_low_cnt) < CE_MAX_CYC);

  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |->
      (((mem_addr_o ^ $past(mem_addr_o)) & ~{{(ADDR_W-4){1'b0}}, addr_mask}) == '0));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_last_o) |-> mem_ce_n_o);

  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n_o) |-> ($past(start_i) && !$past(busy_o)));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && mem_ce_n_o && $past(busy_o)));
endmodule

// File: tb/psram_page_reader_test.sv
`timescale 1ns/1ps
module psram_page_reader_test;
  localparam int  PER   = 5;
  localparam real HALF  = 2.5;
  localparam int  RANDC = (70 + PER - 1) / PER;
  localparam int  PAGEC = (35 + PER - 1) / PER;
  localparam int  DESC  = (15 + PER - 1) / PER;
  localparam int  CEMAX = 40000 / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] start_addr_i = '0;
  logic [1:0]  len_sel_i = '0;
  logic        busy_o, done_o, word_valid_o, word_last_o;
  logic [15:0] word_data_o;
  logic [19:0] mem_addr_o;
  logic        mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_bhe_n_o, mem_ble_n_o;
  logic [15:0] mem_dq_i = 16'hDEAD;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(HALF) clk = ~clk;

  psram_page_reader uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .len_sel_i(len_sel_i), .busy_o(busy_o), .done_o(done_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .word_last_o(word_last_o), .mem_addr_o(mem_addr_o),
    .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o),
    .mem_bhe_n_o(mem_bhe_n_o), .mem_ble_n_o(mem_ble_n_o), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [15:0] stored(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], a[19:8]} ^ 16'h3C5A;
  endfunction

  // memory model: a word is only valid once the access times have elapsed
  realtime t_ce = 0.0;
  realtime t_adr = 0.0;
  always @(negedge mem_ce_n_o) t_ce = $realtime;
  always @(mem_addr_o) t_adr = $realtime;
  always @(negedge clk) begin
    logic [15:0] d;
    if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o &&
        ($realtime + HALF - t_ce) >= 70.0 && ($realtime + HALF - t_adr) >= 35.0)
      d = stored(mem_addr_o);
    else
      d = 16'hDEAD;
    if (mem_bhe_n_o) d[15:8] = 8'hEE;
    if (mem_ble_n_o) d[7:0]  = 8'hEE;
    mem_dq_i <= d;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_burst(input logic [19:0] a, input logic [1:0] sel, input bit poke);
    int          nw;
    logic [3:0]  m;
    int          k = 0;
    int          ce_run = 0;
    int          ce_max = 0;
    bit          seen_done = 0;
    nw = (sel == 2'd0) ? 4 : (sel == 2'd1) ? 8 : 16;
    m  = 4'(nw - 1);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; len_sel_i = sel;
    for (int n = 1; n < 400 && !seen_done; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start_i = 1'b0;
        chk(!mem_ce_n_o && !mem_oe_n_o, "R11 select after accept", mem_ce_n_o, 0);
        chk(mem_we_n_o && !mem_bhe_n_o && !mem_ble_n_o, "R7 strobes",
            {mem_we_n_o, mem_bhe_n_o, mem_ble_n_o}, 3'b100);
      end
      if (poke && n == 30) begin
        start_i = 1'b1; start_addr_i = ~a; len_sel_i = 2'd0;
      end
      if (poke && n == 31) start_i = 1'b0;
      if (!mem_ce_n_o) begin
        ce_run++;
        if (ce_run > ce_max) ce_max = ce_run;
        if (((mem_addr_o ^ a) & ~{16'h0, m}) != 20'h0)
          chk(1'b0, "R3 upper bits moved", int'(mem_addr_o), int'(a));
      end else ce_run = 0;
      if (word_valid_o) begin
        logic [19:0] ea;
        ea = {a[19:4], (a[3:0] & ~m) | ((a[3:0] + 4'(k)) & m)};
        chk(n == RANDC + 1 + k * PAGEC, k == 0 ? "R5 first word time" : "R6 page word time",
            n, RANDC + 1 + k * PAGEC);
        chk(word_data_o == stored(ea), "R4 word order and data", word_data_o, stored(ea));
        chk(word_last_o == (k == nw - 1), "R2 last marker", word_last_o, k == nw - 1);
        k++;
      end
      if (k == nw && !done_o && !word_valid_o)
        chk(mem_ce_n_o && mem_oe_n_o, "R8 deselect gap", mem_ce_n_o, 1);
      if (done_o) begin
        seen_done = 1;
        chk(n == RANDC + 1 + (nw - 1) * PAGEC + DESC, "R8 done time",
            n, RANDC + 1 + (nw - 1) * PAGEC + DESC);
        chk(k == nw, "R2 word count", k, nw);
        chk(!busy_o, "R8 busy low at done", busy_o, 0);
      end
    end
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(ce_max < CEMAX, "R10 select run", ce_max, CEMAX);
    if (poke) begin
      int extra = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!mem_ce_n_o || word_valid_o || busy_o) extra++;
      end
      chk(extra == 0, "R9 no burst from ignored start", extra, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n_o && mem_oe_n_o, "R1 reset select", mem_ce_n_o, 1);
    chk(!word_valid_o && !busy_o && !done_o, "R1 reset flags",
        {word_valid_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n_o && !busy_o && !word_valid_o, "R1 idle after reset",
        {mem_ce_n_o, busy_o, word_valid_o}, 3'b100);
    for (int s = 0; s < 3; s++) begin
      int nw = (s == 0) ? 4 : (s == 1) ? 8 : 16;
      for (int off = 0; off < nw; off++) begin
        logic [3:0]  m  = 4'(nw - 1);
        logic [19:0] hi = (20'h5A3C0 + 20'(s * 17 + off) * 20'h01230) & 20'hFFFF0;
        logic [19:0] a  = hi | {16'h0, (4'(off) & m) | (4'hA & ~m)};
        run_burst(a, 2'(s), 1'b0);
      end
    end
    run_burst(20'hF00F7, 2'd3, 1'b0);
    run_burst(20'h12345, 2'd1, 1'b1);
    run_burst(20'hFFFFF, 2'd2, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule